// File: doc/BRIEF.md
# Interrupt Poll and Recognition Unit

This block decides, one clock at a time, whether a small 8-bit processor core should enter an interrupt at its next instruction boundary. It watches a level-sensitive maskable request line and an edge-sensitive non-maskable request line, both active low. The core's sequencer reports which cycle of the current instruction is running. When a request is pending at the instruction's polling point, the block raises a one-cycle strobe. That strobe tells the fetch stage to swap the next opcode for a break and to start the interrupt-entry sequence.

The polling point depends on the instruction.
- An ordinary instruction polls on its last cycle.
- A branch polls on its second cycle, and only there, whether or not it is taken. A taken branch therefore ignores a request that appears in its final cycle or cycles. That request is served one whole instruction later.

The interrupt-mask flag is seen through a one-boundary delay. The mask value used at a poll is the one captured at the previous poll, so a set-mask or clear-mask instruction acts late. A mask value restored by a return-from-interrupt is loaded at once.

Non-maskable requests are caught by a falling-edge detector into a latch. Only the entry sequencer's acknowledge clears that latch, and the non-maskable request wins when both requests are pending.

Top module: `int_poll_ctl`

## Requirements
- R1: For an instruction that is not a branch (`is_branch`=0), polling happens only in the cycle with `cyc_last`=1. When `int_pending` is 1 in that cycle, `take_int` is 1 for exactly the following clock. At every other cycle `take_int` is 0.
- R2: For a branch (`is_branch`=1), polling happens in the cycle with `br_c2`=1, whether that is the branch's last cycle (not taken) or not (taken).
- R3: Branch cycles with `br_c2`=0 never poll. A maskable request that first appears in the final cycle of a taken branch is taken only at the last cycle of the following instruction.
- R4: In a branch that crosses a page (four cycles), a request that appears in either of the two cycles after `br_c2` is deferred to the next instruction's poll.
- R5: The mask used at a poll (`mask_flag`=1 means masked) is the `mask_flag` value captured at the previous poll. A request held through a clear-mask instruction is therefore not taken at that instruction's end, and is taken at the end of the instruction after it.
- R6: A request present at the poll of a set-mask instruction, while the captured mask is still 0, is taken. At the following instruction's poll, the same request is masked.
- R7: When `rti_load`=1, the current `mask_flag` is used at once, including by a poll in the same cycle, and it is captured for the next poll.
- R8: A falling edge on `nmi_n` sets the non-maskable pending latch at the next clock, whatever the mask. A line that stays low does not set it again after an acknowledge.
- R9: The non-maskable pending latch holds until a clock with `nmi_ack`=1 clears it. A new falling edge in the same cycle as `nmi_ack` wins, and the latch stays set.
- R10: When both requests are pending at a poll, `take_nmi` is 1 with the strobe. `take_nmi` is 0 for a maskable entry and whenever `take_int` is 0.
- R11: After reset, `take_int`=0 and `take_nmi`=0, and the captured mask is 1. `int_pending` = non-maskable latch OR (`irq_n`=0 AND mask in use = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 1 | Maskable request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| mask_flag | input | 1 | Architectural interrupt-mask flag, 1 = masked |
| rti_load | input | 1 | Mask flag was just restored by return-from-interrupt |
| cyc_last | input | 1 | Current cycle is the instruction's last |
| is_branch | input | 1 | Current instruction is a conditional branch |
| br_c2 | input | 1 | Current cycle is the branch's second cycle |
| nmi_ack | input | 1 | Entry sequencer clears the non-maskable latch |
| int_pending | output | 1 | A request would be accepted if polled now |
| take_int | output | 1 | Replace the next opcode with a break |
| take_nmi | output | 1 | The entry being taken is non-maskable |

## Verification
The bench targets the timing cases that are easiest to get wrong.
- A request that appears only in the final cycle of a taken branch, or in the last two cycles of a page-crossing branch. A design that polls at the true end of every instruction would take it one instruction early.
- Clear-mask and set-mask sequences. A design without the mask delay would take the request one instruction too early, or lose the request that arrives just as the mask is set.
- A return-from-interrupt restore. A design that delays this restore like the other mask changes would defer the request.
- Short non-maskable pulses, a line held low, and an acknowledge that collides with a new edge. These expose a latch that re-arms on level, drops early, or loses the edge.
- Simultaneous requests, which check priority.

// File: rtl/int_poll_pkg.sv
package int_poll_pkg;
   typedef enum logic {
      SRC_IRQ = 1'b0,
      SRC_NMI = 1'b1
   } int_src_e;

   localparam int MAX_NMI_SYNC = 4;
endpackage

// File: rtl/int_nmi_latch.sv
module int_nmi_latch #(
   parameter int SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   input  logic ack,
   output logic pend
);
   logic line_s;
   logic line_prev;
   logic fall;

   generate
      if (SYNC == 0) begin : g_direct
         assign line_s = nmi_n;
      end else begin : g_sync
         logic [SYNC-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= nmi_n;
               for (int i = 1; i < SYNC; i++) chain[i] <= chain[i-1];
            end
         end
         assign line_s = chain[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= 1'b1;
      else        line_prev <= line_s;
   end

   assign fall = line_prev & ~line_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (fall) pend <= 1'b1;
      else if (ack)  pend <= 1'b0;
   end

   AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> pend) else $error("edge lost");  // R8
   AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !ack |=> pend) else $error("latch dropped");  // R9
   AST_NMI_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !pend && line_s |=> !pend) else $error("set without edge");  // R8
endmodule

// File: rtl/int_mask_pipe.sv
module int_mask_pipe (
   input  logic clk,
   input  logic rst_n,
   input  logic mask_flag,
   input  logic rti_load,
   input  logic poll,
   output logic mask_use
);
   logic mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mask_q <= 1'b1;
      else if (poll || rti_load) mask_q <= mask_flag;
   end

   assign mask_use = rti_load ? mask_flag : mask_q;

   AST_MASK_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !rti_load && !$past(rti_load) && !$past(poll) |-> $stable(mask_use))
      else $error("mask moved between boundaries");  // R5
endmodule

// File: rtl/int_poll_ctl.sv
module int_poll_ctl
   import int_poll_pkg::*;
#(
   parameter int NMI_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_n,
   input  logic nmi_n,
   input  logic mask_flag,
   input  logic rti_load,
   input  logic cyc_last,
   input  logic is_branch,
   input  logic br_c2,
   input  logic nmi_ack,
   output logic int_pending,
   output logic take_int,
   output logic take_nmi
);
   initial begin
      assert (NMI_SYNC >= 0 && NMI_SYNC <= MAX_NMI_SYNC)
         else $error("NMI_SYNC out of range");
   end

   logic     poll_pt;
   logic     mask_use;
   logic     nmi_pend;
   logic     irq_ok;
   int_src_e take_src;

   // Branches poll on their second cycle only; others on their last cycle.
   assign poll_pt = is_branch ? br_c2 : cyc_last;

   int_mask_pipe u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_flag(mask_flag),
      .rti_load (rti_load),
      .poll     (poll_pt),
      .mask_use (mask_use)
   );

   int_nmi_latch #(.SYNC(NMI_SYNC)) u_nmi (
      .clk  (clk),
      .rst_n(rst_n),
      .nmi_n(nmi_n),
      .ack  (nmi_ack),
      .pend (nmi_pend)
   );

   assign irq_ok      = ~irq_n & ~mask_use;
   assign int_pending = nmi_pend | irq_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_int <= 1'b0;
         take_src <= SRC_IRQ;
      end else begin
         take_int <= poll_pt & int_pending;
         take_src <= (poll_pt & nmi_pend) ? SRC_NMI : SRC_IRQ;
      end
   end

   assign take_nmi = (take_src == SRC_NMI);

   AST_TAKE_AT_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> $past(poll_pt)) else $error("take off poll point");  // R1
   AST_NO_LATE_BRANCH_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      is_branch && !br_c2 |=> !take_int) else $error("late branch poll");  // R3
   AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      take_int && $past(nmi_pend) |-> take_nmi) else $error("priority");  // R10
   AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      take_int && !take_nmi |-> !$past(mask_use)) else $error("masked take");  // R6
   AST_SRC_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take_nmi |-> take_int) else $error("stray source");  // R10
endmodule

// File: tb/int_poll_ctl_tb.sv
module int_poll_ctl_tb;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_n = 1'b1, nmi_n = 1'b1, mask_flag = 1'b1, rti_load = 1'b0;
   logic cyc_last = 1'b0, is_branch = 1'b0, br_c2 = 1'b0, nmi_ack = 1'b0;
   logic int_pending, take_int, take_nmi;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      bit    take;
      bit    nmi;
      bit    cp;
      bit    pend;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   int_poll_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
      .mask_flag(mask_flag), .rti_load(rti_load), .cyc_last(cyc_last),
      .is_branch(is_branch), .br_c2(br_c2), .nmi_ack(nmi_ack),
      .int_pending(int_pending), .take_int(take_int), .take_nmi(take_nmi)
   );

   // Driver: apply one cycle of inputs and queue the result expected after the edge.
   task automatic st(input bit i_n, input bit n_n, input bit m, input bit last,
                     input bit br, input bit c2, input bit rti, input bit ack,
                     input bit e_take, input bit e_nmi, input bit cp, input bit ep,
                     input string tag);
      exp_t e;
      @(negedge clk);
      irq_n = i_n; nmi_n = n_n; mask_flag = m; cyc_last = last;
      is_branch = br; br_c2 = c2; rti_load = rti; nmi_ack = ack;
      e.take = e_take; e.nmi = e_nmi; e.cp = cp; e.pend = ep; e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (take_int !== e.take || take_nmi !== e.nmi || (e.cp && int_pending !== e.pend)) begin
               n_bad++;
               $display("FAIL %s: take=%b nmi=%b pend=%b expected take=%b nmi=%b pend=%b",
                        e.tag, take_int, take_nmi, int_pending, e.take, e.nmi,
                        e.cp ? e.pend : int_pending);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (take_int !== 1'b0 || take_nmi !== 1'b0 || int_pending !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 reset: take=%b nmi=%b pend=%b expected 0 0 0",
                  take_int, take_nmi, int_pending);
      end
      rst_n = 1'b1;
      //  irq nmi m last br c2 rti ack | take nmi cp pend
      st(0,1,0,1,0,0,0,0, 0,0,0,0, "R11 mask set after reset");
      st(1,1,0,0,0,0,0,0, 0,0,1,0, "R11 idle pending");
      st(1,1,0,1,0,0,0,0, 0,0,0,0, "R1 setup");
      // R1: ordinary instruction
      st(0,1,0,0,0,0,0,0, 0,0,1,1, "R1 mid cycle");
      st(0,1,0,0,0,0,0,0, 0,0,0,0, "R1 mid cycle");
      st(0,1,0,1,0,0,0,0, 1,0,1,1, "R1 last cycle");
      st(1,1,0,0,0,0,0,0, 0,0,1,0, "R1 released");
      st(1,1,0,1,0,0,0,0, 0,0,0,0, "R1 idle poll");
      // R2: taken and not-taken branches
      st(1,1,0,0,1,0,0,0, 0,0,0,0, "R2 br c1");
      st(0,1,0,0,1,1,0,0, 1,0,0,0, "R2 taken c2");
      st(1,1,0,1,1,0,0,0, 0,0,0,0, "R2 taken c3");
      st(1,1,0,0,1,0,0,0, 0,0,0,0, "R2 nt c1");
      st(0,1,0,1,1,1,0,0, 1,0,0,0, "R2 not-taken c2");
      st(1,1,0,1,0,0,0,0, 0,0,0,0, "R2 idle");
      // R3: request only in taken-branch final cycle
      st(1,1,0,0,1,0,0,0, 0,0,0,0, "R3 c1");
      st(1,1,0,0,1,1,0,0, 0,0,0,0, "R3 c2");
      st(0,1,0,1,1,0,0,0, 0,0,1,1, "R3 final cycle ignored");
      st(0,1,0,0,0,0,0,0, 0,0,0,0, "R3 next inst mid");
      st(0,1,0,1,0,0,0,0, 1,0,0,0, "R3 deferred take");
      st(1,1,0,1,0,0,0,0, 0,0,0,0, "R3 idle");
      // R4: page-crossing branch
      st(1,1,0,0,1,0,0,0, 0,0,0,0, "R4 c1");
      st(1,1,0,0,1,1,0,0, 0,0,0,0, "R4 c2");
      st(0,1,0,0,1,0,0,0, 0,0,0,0, "R4 c3 ignored");
      st(0,1,0,1,1,0,0,0, 0,0,0,0, "R4 c4 ignored");
      st(0,1,0,1,0,0,0,0, 1,0,0,0, "R4 deferred take");
      st(1,1,0,1,0,0,0,0, 0,0,0,0, "R4 idle");
      // R6: set-mask instruction
      st(0,1,0,0,0,0,0,0, 0,0,0,0, "R6 sei c1");
      st(0,1,1,1,0,0,0,0, 1,0,1,0, "R6 taken at sei end");
      st(0,1,1,0,0,0,0,0, 0,0,0,0, "R6 next mid");
      st(0,1,1,1,0,0,0,0, 0,0,1,0, "R6 masked next poll");
      // R5: clear-mask instruction
      st(0,1,1,0,0,0,0,0, 0,0,0,0, "R5 cli c1");
      st(0,1,0,1,0,0,0,0, 0,0,1,1, "R5 not at cli end");
      st(0,1,0,1,0,0,0,0, 1,0,0,0, "R5 taken one later");
      st(1,1,0,1,0,0,0,0, 0,0,0,0, "R5 idle");
      // R7: return-from-interrupt restore
      st(1,1,1,1,0,0,0,0, 0,0,0,0, "R7 mask on");
      st(0,1,1,0,0,0,0,0, 0,0,1,0, "R7 masked before restore");
      st(0,1,0,0,0,0,1,0, 0,0,1,1, "R7 restore");
      st(0,1,0,1,0,0,0,0, 1,0,0,0, "R7 taken next poll");
      st(1,1,1,1,0,0,0,0, 0,0,0,0, "R7 mask on");
      st(0,1,0,1,0,0,1,0, 1,0,0,0, "R7 same-cycle restore");
      st(1,1,1,1,0,0,0,0, 0,0,0,0, "R7 mask on");
      // R8: edge, mask ignored, no level retrigger
      st(1,0,1,0,0,0,0,0, 0,0,1,1, "R8 edge sets");
      st(1,0,1,1,0,0,0,0, 1,1,0,0, "R8 taken though masked");
      st(1,0,1,0,0,0,0,1, 0,0,1,0, "R8 ack clears");
      st(1,0,1,1,0,0,0,0, 0,0,1,0, "R8 held low no retrigger");
      st(1,1,1,0,0,0,0,0, 0,0,0,0, "R8 release");
      // R9: short pulse held, ack collision
      st(1,0,1,0,0,0,0,0, 0,0,1,1, "R9 pulse");
      st(1,1,1,0,0,0,0,0, 0,0,1,1, "R9 held");
      st(1,1,1,0,0,0,0,0, 0,0,1,1, "R9 held");
      st(1,1,1,1,0,0,0,0, 1,1,0,0, "R9 taken later");
      st(1,1,1,0,0,0,0,1, 0,0,1,0, "R9 ack");
      st(1,0,1,0,0,0,0,1, 0,0,1,1, "R9 edge beats ack");
      st(1,1,1,0,0,0,0,1, 0,0,1,0, "R9 ack clears");
      // R10: priority
      st(1,1,0,1,0,0,0,0, 0,0,1,0, "R10 unmask");
      st(0,0,0,0,0,0,0,0, 0,0,1,1, "R10 both");
      st(0,1,0,1,0,0,0,0, 1,1,0,0, "R10 nmi first");
      st(0,1,0,0,0,0,0,1, 0,0,1,1, "R10 ack nmi");
      st(0,1,0,1,0,0,0,0, 1,0,0,0, "R10 irq after");
      st(1,1,0,1,0,0,0,0, 0,0,1,0, "R10 idle");
      @(negedge clk);
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule